// File: doc/BRIEF.md
# SPI Host Controller with Memory-Mapped Registers

This block is a serial peripheral interface master that a processor drives through a small 32-bit register window using a single-cycle request/acknowledge handshake. Software loads up to 128 bits of outgoing data into four data words, picks the transfer length, the clock edge used to change the outgoing line, the clock edge used to capture the incoming line, and whether the least or most significant bit leads. Setting the start bit in the control word launches the transfer. The same bit then reads as a busy flag until the last serial clock edge.

The serial clock idles low. Its half period is the divider value plus one system clock, so a divider of zero gives the fastest rate. Incoming bits replace the outgoing bits in the shared data words, filling them from bit 0 of word 0 upward. Eight active-low select lines either mirror a select register directly or, in automatic mode, go active only while a transfer runs. An optional interrupt marks the end of a transfer and is cleared by reading a data word.

Word offsets (byte address bits 4:2): data words 0–3 at 0–3, control at 4, divider at 5, select at 6; unmapped offsets read zero.

Top module: `spi_host_ctrl`

## Requirements
- R1: Data words, control, divider and select registers read back the value last written; control bits 7 and 31:14 read as 0, and everything is 0 after reset with all select lines high, the serial clock low and the interrupt low.
- R2: Each byte lane of a write is applied only when its byte-select bit is set; unselected lanes keep their previous contents.
- R3: Every access with cyc and stb high is acknowledged in the same cycle, and the error output stays low.
- R4: Writing control with bit 8 set while idle starts a transfer; bit 8 then reads 1 until the transfer ends and 0 afterwards.
- R5: The serial clock idles low, changes level once every (divider + 1) system clocks during a transfer, and makes exactly two edges per bit; the first edge is rising.
- R6: Control bits 6:0 give the length in bits; 1 means a single bit and 0 means 128 bits.
- R7: With control bit 10 clear the outgoing line changes on rising serial clock edges; with it set it changes on falling edges and the first bit is already valid before the first rising edge.
- R8: With control bit 9 clear the incoming line is captured on rising serial clock edges; with it set, on falling edges.
- R9: With control bit 11 clear bits go most significant first (bit length−1 down to bit 0); with it set, bit 0 first. The k-th received bit lands in the same position the k-th sent bit came from, and bits at and above the length keep their previous value.
- R10: With control bit 12 set the interrupt rises together with the end of busy and falls the cycle after a data word is read.
- R11: With control bit 13 clear each select line is the inverse of its select register bit; with it set, enabled lines go low only while busy and all lines are high otherwise.
- R12: While busy, writes to control, divider and data words are ignored and do not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_adr | input | 3 | Word offset (byte address bits 4:2) |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data |
| bus_sel | input | 4 | Byte lane selects |
| bus_we | input | 1 | Write enable |
| bus_stb | input | 1 | Strobe |
| bus_cyc | input | 1 | Cycle valid |
| bus_ack | output | 1 | Acknowledge |
| bus_err | output | 1 | Error, always low |
| irq | output | 1 | End-of-transfer interrupt |
| sel_n | output | NSEL | Active-low slave selects |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong divider count or a lost toggle in the clock generator shows on the serial clock pin at the first edge that lands on the wrong system clock, and the per-clock comparison of clock, select lines and interrupt flags it there. A wrong bit index, length decode or edge choice in the shift engine does not show until the transfer ends, when the bits captured by the modelled slave and the words read back disagree with the expected pattern. A stale mode or busy state shows as a select line or interrupt that changes on the wrong cycle, or as a busy flag read back with the wrong value.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int MAX_BITS  = 128;
    localparam int LEN_W     = $clog2(MAX_BITS);
    localparam int WORDS     = MAX_BITS / 32;

    // word offsets (byte address bits 4:2)
    localparam logic [2:0] OFS_CTRL = 3'd4;
    localparam logic [2:0] OFS_DIV  = 3'd5;
    localparam logic [2:0] OFS_SEL  = 3'd6;

    // control bit positions
    localparam int B_GO   = 8;
    localparam int B_RXF  = 9;
    localparam int B_TXF  = 10;
    localparam int B_LSB  = 11;
    localparam int B_IE   = 12;
    localparam int B_AUTO = 13;

    typedef struct packed {
        logic             auto_sel;
        logic             irq_en;
        logic             lsb_first;
        logic             tx_fall;
        logic             rx_fall;
        logic [LEN_W-1:0] len;
    } mode_t;

    function automatic logic [31:0] mode_to_word(input mode_t m, input logic go);
        logic [31:0] w;
        w            = '0;
        w[LEN_W-1:0] = m.len;
        w[B_GO]      = go;
        w[B_RXF]     = m.rx_fall;
        w[B_TXF]     = m.tx_fall;
        w[B_LSB]     = m.lsb_first;
        w[B_IE]      = m.irq_en;
        w[B_AUTO]    = m.auto_sel;
        return w;
    endfunction

    function automatic mode_t word_to_mode(input logic [31:0] w);
        mode_t m;
        m.len       = w[LEN_W-1:0];
        m.rx_fall   = w[B_RXF];
        m.tx_fall   = w[B_TXF];
        m.lsb_first = w[B_LSB];
        m.irq_en    = w[B_IE];
        m.auto_sel  = w[B_AUTO];
        return m;
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                               input logic [31:0] new_w,
                                               input logic [3:0]  be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
        return r;
    endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             rise,
    output logic             fall
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sck;
    } gen_t;

    gen_t s_d, s_q;
    logic tick;

    assign tick = run && (s_q.cnt == '0);
    assign rise = tick & ~s_q.sck;
    assign fall = tick &  s_q.sck;
    assign sck  = s_q.sck;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.cnt = div;
            s_d.sck = 1'b0;
        end else if (run) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = div;
                s_d.sck = ~s_q.sck;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else begin
            s_d.sck = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R5: a clock edge is only produced while a transfer runs
    a_r5_edge_only_running: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(s_q.sck) || !s_q.sck);

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rise,
    input  logic             fall,
    input  mode_t            mode,
    input  logic             tx_bit,
    output logic             busy,
    output logic             done,
    output logic             mosi,
    output logic [LEN_W-1:0] tx_pos,
    output logic [LEN_W-1:0] rx_pos,
    output logic             rx_we
);

    localparam int CNT_W = LEN_W + 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] idx;
        logic             mosi;
    } eng_t;

    eng_t e_d, e_q;
    logic [CNT_W-1:0] nbits;
    logic             last;
    logic             launch;

    assign nbits = (mode.len == '0) ? CNT_W'(MAX_BITS) : {1'b0, mode.len};
    assign last  = (e_q.idx == nbits - 1'b1);
    assign busy  = e_q.busy;
    assign mosi  = e_q.mosi;

    function automatic logic [LEN_W-1:0] bit_pos(input logic [CNT_W-1:0] j,
                                                 input logic [CNT_W-1:0] n,
                                                 input logic             lsb);
        logic [CNT_W-1:0] t;
        t = lsb ? j : (n - 1'b1 - j);
        return t[LEN_W-1:0];
    endfunction

    always_comb begin
        e_d    = e_q;
        done   = 1'b0;
        tx_pos = bit_pos(fall ? e_q.idx + 1'b1 : e_q.idx, nbits, mode.lsb_first);
        rx_pos = bit_pos(e_q.idx, nbits, mode.lsb_first);
        rx_we  = e_q.busy & ((rise & ~mode.rx_fall) | (fall & mode.rx_fall));
        launch = (start & mode.tx_fall)
               | (e_q.busy & rise & ~mode.tx_fall)
               | (e_q.busy & fall & mode.tx_fall & ~last);
        if (start) begin
            e_d.busy = 1'b1;
            e_d.idx  = '0;
        end
        if (launch) e_d.mosi = tx_bit;
        if (e_q.busy && fall) begin
            if (last) begin
                e_d.busy = 1'b0;
                e_d.idx  = '0;
                done     = 1'b1;
            end else begin
                e_d.idx = e_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) e_q <= '0;
        else     e_q <= e_d;
    end

    // R6: bit index never leaves the programmed length
    a_r6_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        e_q.busy |-> e_q.idx < nbits);

    // R5: a transfer ends only on a falling serial clock edge
    a_r5_end_on_fall: assert property (@(posedge clk) disable iff (rst)
        done |-> fall);

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int NSEL  = 8,
    parameter int DIV_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      bus_adr,
    input  logic [31:0]     bus_wdat,
    output logic [31:0]     bus_rdat,
    input  logic [3:0]      bus_sel,
    input  logic            bus_we,
    input  logic            bus_stb,
    input  logic            bus_cyc,
    output logic            bus_ack,
    output logic            bus_err,
    output logic            irq,
    output logic [NSEL-1:0] sel_n,
    output logic            sck,
    output logic            mosi,
    input  logic            miso
);

    localparam int DBITS = WORDS * 32;

    typedef struct packed {
        logic [DBITS-1:0] data;
        mode_t            mode;
        logic [DIV_W-1:0] div;
        logic [NSEL-1:0]  ss;
        logic             irq;
    } regs_t;

    regs_t r_d, r_q;

    logic             acc, wr, rd, is_data, start;
    logic [31:0]      ctrl_new;
    mode_t            mode_eff;
    logic             busy, done, rx_we, tx_bit, rise, fall;
    logic [LEN_W-1:0] tx_pos, rx_pos;

    // ---- bus decode ----
    always_comb begin
        acc      = bus_cyc & bus_stb;
        wr       = acc & bus_we;
        rd       = acc & ~bus_we;
        is_data  = (bus_adr[2] == 1'b0) && (bus_adr[1:0] <= 2'(WORDS - 1)) && !bus_adr[2];
        is_data  = ~bus_adr[2];
        ctrl_new = lane_merge(mode_to_word(r_q.mode, 1'b0), bus_wdat, bus_sel);
        start    = wr && (bus_adr == OFS_CTRL) && !busy && bus_sel[1] && bus_wdat[B_GO];
        mode_eff = start ? word_to_mode(ctrl_new) : r_q.mode;
    end

    assign tx_bit  = r_q.data[tx_pos];
    assign bus_ack = acc;
    assign bus_err = 1'b0;
    assign irq     = r_q.irq;
    assign sel_n   = ~(r_q.mode.auto_sel ? (busy ? r_q.ss : '0) : r_q.ss);

    spi_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .run   (busy),
        .div   (r_q.div),
        .sck   (sck),
        .rise  (rise),
        .fall  (fall)
    );

    spi_bit_engine u_eng (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .rise   (rise),
        .fall   (fall),
        .mode   (mode_eff),
        .tx_bit (tx_bit),
        .busy   (busy),
        .done   (done),
        .mosi   (mosi),
        .tx_pos (tx_pos),
        .rx_pos (rx_pos),
        .rx_we  (rx_we)
    );

    // ---- next state ----
    always_comb begin
        logic [31:0] tmp;
        r_d = r_q;
        tmp = '0;
        if (wr && !busy) begin
            if (is_data) begin
                r_d.data[{bus_adr[1:0], 5'd0} +: 32] =
                    lane_merge(r_q.data[{bus_adr[1:0], 5'd0} +: 32], bus_wdat, bus_sel);
            end else if (bus_adr == OFS_CTRL) begin
                r_d.mode = word_to_mode(ctrl_new);
            end else if (bus_adr == OFS_DIV) begin
                tmp       = lane_merge(32'(r_q.div), bus_wdat, bus_sel);
                r_d.div   = tmp[DIV_W-1:0];
            end
        end
        if (wr && bus_adr == OFS_SEL) begin
            tmp      = lane_merge(32'(r_q.ss), bus_wdat, bus_sel);
            r_d.ss   = tmp[NSEL-1:0];
        end
        if (rx_we) r_d.data[rx_pos] = miso;
        if (start || (rd && is_data)) r_d.irq = 1'b0;
        if (done && r_q.mode.irq_en)  r_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    // ---- read mux ----
    always_comb begin
        bus_rdat = '0;
        if (is_data)                    bus_rdat = r_q.data[{bus_adr[1:0], 5'd0} +: 32];
        else if (bus_adr == OFS_CTRL)   bus_rdat = mode_to_word(r_q.mode, busy);
        else if (bus_adr == OFS_DIV)    bus_rdat = 32'(r_q.div);
        else if (bus_adr == OFS_SEL)    bus_rdat = 32'(r_q.ss);
    end

    // ---- assertions ----
    // R5: serial clock is low whenever no transfer runs
    a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    // R4: busy only drops right after the clock was high
    a_r4_end_after_high: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(sck));

    // R10: interrupt only rises when a transfer finishes
    a_r10_irq_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $fell(busy));

    // R12: transfer mode does not change while busy
    a_r12_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(r_q.mode));

    // R11: automatic select keeps every line high when idle
    a_r11_auto_idle_high: assert property (@(posedge clk) disable iff (rst)
        (r_q.mode.auto_sel && !busy) |-> (sel_n == '1));

endmodule

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  adr;
    logic [31:0] wdat;
    logic [31:0] rdat;
    logic [3:0]  sel;
    logic        we, stb, cyc;
    logic        bus_ack, bus_err, irq, sck, mosi, miso;
    logic [7:0]  sel_n;

    int checks = 0;
    int errors = 0;
    bit fin    = 1'b0;

    always #2 clk = ~clk;

    spi_host_ctrl dut (
        .clk(clk), .rst(rst), .bus_adr(adr), .bus_wdat(wdat), .bus_rdat(rdat),
        .bus_sel(sel), .bus_we(we), .bus_stb(stb), .bus_cyc(cyc),
        .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq), .sel_n(sel_n),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---- bus master ----
    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        adr = a; wdat = d; sel = be; we = 1'b1; cyc = 1'b1; stb = 1'b1;
        #1;
        chk(bus_ack === 1'b1 && bus_err === 1'b0, "R3 write ack", {bus_ack, bus_err}, 2'b10);
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        adr = a; sel = 4'hF; we = 1'b0; cyc = 1'b1; stb = 1'b1;
        #1;
        d = rdat;
        chk(bus_ack === 1'b1 && bus_err === 1'b0, "R3 read ack", {bus_ack, bus_err}, 2'b10);
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0;
    endtask

    function automatic logic [31:0] ctrlw(input int n, input bit rxf, txf, lsb, ie, aut);
        logic [31:0] w;
        w      = '0;
        w[6:0] = 7'(n % 128);
        w[9]   = rxf; w[10] = txf; w[11] = lsb; w[12] = ie; w[13] = aut;
        return w;
    endfunction

    // ---- slave model ----
    bit   s_bits [0:128];
    logic got    [0:128];
    int   rc, fc;
    bit   s_txf, s_rxf;
    logic miso_r = 1'b0;
    assign miso = miso_r;

    always @(posedge sck) begin
        if (s_txf && rc <= 128) got[rc] = mosi;
        if (s_rxf && rc <= 128) miso_r = s_bits[rc];
        rc = rc + 1;
    end

    always @(negedge sck) begin
        if (!s_txf && fc <= 128) got[fc] = mosi;
        if (!s_rxf && fc < 128) miso_r = s_bits[fc + 1];
        fc = fc + 1;
    end

    // ---- per-clock reference of sck, selects, interrupt ----
    int         m;
    bit         trk = 1'b0;
    int         t_n, t_div;
    bit         t_ie, t_aut;
    logic [7:0] t_ss;
    int         mism;
    logic [9:0] f_act, f_exp;

    always @(posedge clk) if (trk) m = m + 1;

    always @(negedge clk) begin
        if (trk) begin
            int tog;
            int tot;
            bit bz;
            logic [9:0] ev, av;
            tot = 2 * t_n;
            tog = m / (t_div + 1);
            bz  = (tog < tot);
            if (!bz) tog = tot;
            ev  = {t_ie & ~bz, (t_aut ? (bz ? ~t_ss : 8'hFF) : ~t_ss), tog[0]};
            av  = {irq, sel_n, sck};
            if (av !== ev) begin
                if (mism == 0) begin f_act = av; f_exp = ev; end
                mism++;
            end
        end
    end

    logic [7:0] cur_ss;

    task automatic run(input int n, input bit rxf, txf, lsb, ie, aut, input int dv,
                       input logic [127:0] txd, input logic [127:0] sdat,
                       input bit midw, input string tag);
        logic [31:0]  cw, q;
        logic [127:0] rxv, exp_rx;
        int           tot, p, bad;
        cw = ctrlw(n, rxf, txf, lsb, ie, aut);
        wr(3'd5, 32'(dv), 4'hF);
        for (int w = 0; w < 4; w++) wr(3'(w), txd[w*32 +: 32], 4'hF);
        wr(3'd4, cw, 4'hF);
        s_txf = txf; s_rxf = rxf; rc = 0; fc = 0;
        for (int k = 0; k < 128; k++) s_bits[k] = sdat[k];
        s_bits[128] = 1'b0;
        for (int k = 0; k <= 128; k++) got[k] = 1'bx;
        miso_r = rxf ? 1'b0 : s_bits[0];
        t_n = n; t_div = dv; t_ie = ie; t_aut = aut; t_ss = cur_ss; mism = 0;
        @(negedge clk);
        adr = 3'd4; wdat = cw | 32'h100; sel = 4'hF; we = 1'b1; cyc = 1'b1; stb = 1'b1;
        @(posedge clk);
        #1; m = 0; trk = 1'b1;
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        rd(3'd4, q);
        chk(q[8] === 1'b1, {tag, " R4 busy reads 1"}, q[8], 1'b1);
        if (midw) begin
            wr(3'd4, ctrlw(5, ~rxf, ~txf, ~lsb, ie, aut) | 32'h100, 4'hF);
            wr(3'd5, 32'd7, 4'hF);
            wr(3'd0, 32'h0, 4'hF);
        end
        tot = 2 * n * (dv + 1);
        while (m < tot + 1) @(negedge clk);
        rd(3'd4, q);
        chk(q[8] === 1'b0 && q[13:0] === {cw[13:9], 1'b0, cw[7:0]},
            {tag, " R4/R12 control after end"}, q, cw);
        chk(irq === ie, {tag, " R10 irq at end"}, irq, ie);
        trk = 1'b0;
        chk(mism == 0, {tag, " R5/R11/R10 per-clock sck,sel_n,irq"}, f_act, f_exp);
        for (int w = 0; w < 4; w++) begin
            rd(3'(w), q);
            rxv[w*32 +: 32] = q;
            if (w == 0 && ie) chk(irq === 1'b0, {tag, " R10 irq cleared by read"}, irq, 1'b0);
        end
        exp_rx = txd;
        bad = 0;
        for (int k = 0; k < n; k++) begin
            p = lsb ? k : n - 1 - k;
            exp_rx[p] = sdat[k];
            if (got[k] !== txd[p]) bad++;
        end
        chk(rxv === exp_rx, {tag, " R8/R9 received words"}, rxv, exp_rx);
        chk(bad == 0, {tag, " R7/R9 bits seen by slave"}, bad, 0);
    endtask

    initial begin
        logic [31:0] q;
        rst = 1'b1; adr = '0; wdat = '0; sel = '0; we = 1'b0; stb = 1'b0; cyc = 1'b0;
        cur_ss = 8'h00;
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(sel_n === 8'hFF && sck === 1'b0 && irq === 1'b0 && bus_err === 1'b0,
            "R1 reset outputs", {sel_n, sck, irq, bus_err}, {8'hFF, 3'b000});
        rd(3'd4, q); chk(q === 32'h0, "R1 reset control", q, 32'h0);
        rd(3'd5, q); chk(q === 32'h0, "R1 reset divider", q, 32'h0);

        // R1 register readback
        wr(3'd5, 32'h0000_1234, 4'hF); rd(3'd5, q);
        chk(q === 32'h1234, "R1 divider readback", q, 32'h1234);
        wr(3'd6, 32'h0000_00A5, 4'hF); rd(3'd6, q);
        chk(q === 32'hA5, "R1 select readback", q, 32'hA5);
        wr(3'd4, 32'hFFFF_FEFF, 4'hF); rd(3'd4, q);
        chk(q === 32'h0000_3E7F, "R1 control readback, unused bits zero", q, 32'h3E7F);
        #1; chk(sel_n === 8'hFF, "R11 automatic select idle high", sel_n, 8'hFF);
        wr(3'd4, 32'h0000_0000, 4'hF);
        #1; chk(sel_n === 8'h5A, "R11 direct select follows register", sel_n, 8'h5A);
        wr(3'd2, 32'hDEAD_BEEF, 4'hF); rd(3'd2, q);
        chk(q === 32'hDEADBEEF, "R1 data word readback", q, 32'hDEADBEEF);
        rd(3'd7, q); chk(q === 32'h0, "R1 unmapped reads zero", q, 32'h0);

        // R2 byte lanes
        wr(3'd6, 32'h00FF_FF3C, 4'b1110); rd(3'd6, q);
        chk(q === 32'hA5, "R2 select low lane not written", q, 32'hA5);
        wr(3'd1, 32'h1122_3344, 4'hF);
        wr(3'd1, 32'hAABB_CCDD, 4'b0101); rd(3'd1, q);
        chk(q === 32'h11BB33DD, "R2 data partial lanes", q, 32'h11BB33DD);

        cur_ss = 8'h01; wr(3'd6, 32'h01, 4'hF);
        run(8,   1, 0, 0, 0, 0, 0, 128'h5A, 128'hA5, 0, "T1");
        run(8,   0, 1, 0, 0, 0, 2, 128'hA5, 128'h96, 0, "T2");
        run(16,  0, 1, 1, 0, 0, 0, 128'h5AA5, 128'h7E5A, 0, "T3");
        run(64,  1, 0, 1, 0, 0, 1, 128'hFEDCBA98_76543210, 128'h5AA5A55A_0F1E2D3C, 0, "T4");
        run(128, 0, 1, 0, 0, 0, 0, 128'h00112233_44556677_8899AABB_CCDDEEFF,
            128'h195D3B7F_C3A5960F_13579BDF_2468ACE0, 0, "T5 R6 len0");
        run(32,  0, 1, 0, 1, 0, 0, 128'hAA55A5A5, 128'hCCDDEEFF, 0, "T6");
        cur_ss = 8'h24; wr(3'd6, 32'h24, 4'hF);
        run(32,  1, 0, 0, 1, 1, 1, 128'h01248421, 128'h89ABCDEF, 0, "T7");
        run(1,   1, 0, 0, 1, 1, 0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFE, 128'h1, 0, "T8 R6 len1");
        run(20,  0, 0, 1, 0, 1, 1, 128'h000F_0F0F, 128'h000A_5A5A, 1, "T9 R12 busy writes");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        fin = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule